// File: doc/BRIEF.md
# Paged Monitor Register Window

This block is a byte-wide register bank that a host reaches through a 256-address I/O window. One control register holds a lock bit and an error flag. One select register picks which of 16 internal pages is visible. The remaining range, from 0x10 to 0xFE, is a data window onto the selected page. Each page stores 239 bytes. The host reads and writes through a plain address/data/strobe bus, and reads are combinational.

An update works as a short handshake. The host clears the lock bit, writes into one or more pages, then sets the lock bit again. The 0-to-1 edge of the lock bit commits the update. On that edge the device side gets a one-cycle notification and a mask of the pages written since the last commit. A window write made while the lock bit is set is dropped and raises a sticky error flag.

One byte on page 1 sets the duty of an 8-bit PWM output. The PWM takes a new value from that byte only at a commit. The device side can also read any page directly through its own read port.

Top module: `paged_mon_window`

## Requirements
- R1: Address map. Offset 0x04 is the control register, with bit 0 the lock bit and bit 1 the error flag. Offsets 0x10 to 0xFE are the paged window, and offset 0xFF is page select. After reset the control register reads 0x01, page select reads 0x00, every page byte reads 0x00, the notification is low, the mask is zero and the PWM output is low.
- R2: Offsets 0x00–0x03 and 0x05–0x0F read as 0x00. Writes to them change no readable state.
- R3: A write to 0xFF keeps bits 3:0 as the page number, and bits 7:4 read back as zero. The very next window access uses the new page.
- R4: While the lock bit is 0, a window write at offset A stores the byte at index A−0x10 of the selected page. Pages are independent of each other.
- R5: While the lock bit is 1, a window write changes no page byte and sets the error flag. Writing 1 to control bit 1 clears the flag. Writing 0 to bit 1 leaves it unchanged.
- R6: A control write that takes the lock bit from 0 to 1 drives devChanged high for exactly the one cycle after that write's clock edge. In the same cycle, devPageMask shows one bit per page written since the previous commit (bit n = page n). Writing 1 when the lock bit is already 1 gives no pulse.
- R7: hostRdData follows hostAddr combinationally whenever hostRd is high, in any lock state, and reads have no side effects. hostRdData is 0x00 when hostRd is low.
- R8: Over any 256 consecutive cycles, pwmOut is high for exactly D cycles. D is the value of page 1 offset 0x98 as captured at the latest commit, and is 0 before any commit. Uncommitted writes to that byte do not change D.
- R9: devRdData returns the stored byte of page devRdPage at window offset devRdOff, and returns 0x00 for an offset outside 0x10–0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 8 | Host byte offset within the window |
| hostWrData | input | 8 | Host write data |
| hostWr | input | 1 | Host write strobe, one cycle per write |
| hostRd | input | 1 | Host read enable |
| hostRdData | output | 8 | Host read data (combinational) |
| devRdPage | input | 4 | Device-side read page |
| devRdOff | input | 8 | Device-side read offset |
| devRdData | output | 8 | Device-side read data |
| devChanged | output | 1 | One-cycle commit notification |
| devPageMask | output | 16 | Pages touched in the committed update |
| pwmOut | output | 1 | PWM duty output |

## Verification
A single control write can both commit the update and clear the error flag when its data is 0x03. That write therefore sets the lock bit, fires the notification and clears the sticky error, all at the same edge. The bench first leaves a locked window write pending so that the error is set. It then unlocks, edits the duty byte and issues that combined write. It judges the result by reading the control register back as 0x01, by seeing the pulse with the expected page mask, and by measuring the new PWM duty. A second collision is an uncommitted edit of the duty byte while the PWM runs; the measured duty must stay at its old value.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
  // strobes handed from the decoder to the datapath
  typedef struct packed {
    logic winHit;   // current address falls in the paged window
    logic winWr;    // accepted window write (lock open)
    logic commit;   // lock bit rising edge this cycle
  } pmwStrobe_t;
endpackage

// File: rtl/pmw_ctrl.sv
module pmw_ctrl
  import pmw_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int PAGES    = 16,
  parameter int CTRL_OFF = 'h04,
  parameter int WIN_LO   = 'h10,
  parameter int WIN_HI   = 'hFE,
  parameter int PSEL_OFF = 'hFF,
  localparam int PAGE_W  = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostWr,
  output pmwStrobe_t        strobe,
  output logic [PAGE_W-1:0] page,
  output logic [DATA_W-1:0] regRdData,
  output logic              devChanged,
  output logic [PAGES-1:0]  devPageMask
);
  logic hitCtrl, hitPsel, hitWin;
  logic lockBit, errFlag;
  logic [PAGES-1:0] touched;

  assign hitCtrl = (hostAddr == ADDR_W'(CTRL_OFF));
  assign hitPsel = (hostAddr == ADDR_W'(PSEL_OFF));
  assign hitWin  = (hostAddr >= ADDR_W'(WIN_LO)) && (hostAddr <= ADDR_W'(WIN_HI));

  assign strobe.winHit = hitWin;
  assign strobe.winWr  = hostWr && hitWin && !lockBit;
  assign strobe.commit = hostWr && hitCtrl && hostWrData[0] && !lockBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockBit     <= 1'b1;
      errFlag     <= 1'b0;
      page        <= '0;
      touched     <= '0;
      devChanged  <= 1'b0;
      devPageMask <= '0;
    end else begin
      devChanged <= strobe.commit;
      if (hostWr && hitCtrl) lockBit <= hostWrData[0];
      if (hostWr && hitWin && lockBit) errFlag <= 1'b1;
      else if (hostWr && hitCtrl && hostWrData[1]) errFlag <= 1'b0;
      if (hostWr && hitPsel) page <= hostWrData[PAGE_W-1:0];
      if (strobe.commit) begin
        devPageMask <= touched;
        touched     <= '0;
      end else if (strobe.winWr) begin
        touched[page] <= 1'b1;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (hitCtrl)      regRdData = DATA_W'({errFlag, lockBit});
    else if (hitPsel) regRdData = DATA_W'(page);
  end

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    devChanged |=> !devChanged);
  p_pulse_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    devChanged |-> lockBit);
  p_locked_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hitWin && lockBit) |=> errFlag);
  p_locked_no_mark_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hitWin && lockBit) |=> $stable(touched));
endmodule

// File: rtl/pmw_datapath.sv
module pmw_datapath
  import pmw_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int PAGES    = 16,
  parameter int CTRL_OFF = 'h04,
  parameter int WIN_LO   = 'h10,
  parameter int WIN_HI   = 'hFE,
  parameter int PSEL_OFF = 'hFF,
  parameter int PWM_PAGE = 1,
  parameter int PWM_OFF  = 'h98,
  localparam int PAGE_W  = $clog2(PAGES),
  localparam int DEPTH   = WIN_HI - WIN_LO + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  pmwStrobe_t        strobe,
  input  logic [PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic [PAGE_W-1:0] devRdPage,
  input  logic [ADDR_W-1:0] devRdOff,
  output logic [DATA_W-1:0] devRdData,
  output logic              pwmOut
);
  localparam logic [ADDR_W-1:0] PWM_IDX = ADDR_W'(PWM_OFF - WIN_LO);

  logic [DATA_W-1:0] mem [PAGES][DEPTH];
  logic [ADDR_W-1:0] hostIdx, devIdx;
  logic              devInWin;
  logic [DATA_W-1:0] dutyReg, pwmCnt;

  assign hostIdx  = hostAddr - ADDR_W'(WIN_LO);
  assign devIdx   = devRdOff - ADDR_W'(WIN_LO);
  assign devInWin = (devRdOff >= ADDR_W'(WIN_LO)) && (devRdOff <= ADDR_W'(WIN_HI));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < PAGES; p++)
        for (int i = 0; i < DEPTH; i++)
          mem[p][i] <= '0;
    end else if (strobe.winWr) begin
      mem[page][hostIdx] <= hostWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dutyReg <= '0;
      pwmCnt  <= '0;
    end else begin
      pwmCnt <= pwmCnt + 1'b1;
      if (strobe.commit) dutyReg <= mem[PWM_PAGE][PWM_IDX];
    end
  end

  assign pwmOut = (pwmCnt < dutyReg);

  always_comb begin
    hostRdData = '0;
    if (hostRd) hostRdData = strobe.winHit ? mem[page][hostIdx] : regRdData;
  end

  assign devRdData = devInWin ? mem[devRdPage][devIdx] : '0;

  p_duty_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(dutyReg));
  p_page_upper_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == ADDR_W'(PSEL_OFF)) |-> (hostRdData[DATA_W-1:PAGE_W] == '0));
  p_undef_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr < ADDR_W'(WIN_LO) && hostAddr != ADDR_W'(CTRL_OFF)) |-> (hostRdData == '0));
endmodule

// File: rtl/paged_mon_window.sv
module paged_mon_window
  import pmw_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int PAGES    = 16,
  parameter int CTRL_OFF = 'h04,
  parameter int WIN_LO   = 'h10,
  parameter int WIN_HI   = 'hFE,
  parameter int PSEL_OFF = 'hFF,
  parameter int PWM_PAGE = 1,
  parameter int PWM_OFF  = 'h98,
  localparam int PAGE_W  = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostWr,
  input  logic              hostRd,
  output logic [DATA_W-1:0] hostRdData,
  input  logic [PAGE_W-1:0] devRdPage,
  input  logic [ADDR_W-1:0] devRdOff,
  output logic [DATA_W-1:0] devRdData,
  output logic              devChanged,
  output logic [PAGES-1:0]  devPageMask,
  output logic              pwmOut
);
  pmwStrobe_t        strobe;
  logic [PAGE_W-1:0] page;
  logic [DATA_W-1:0] regRdData;

  pmw_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGES(PAGES), .CTRL_OFF(CTRL_OFF),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .PSEL_OFF(PSEL_OFF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostWr(hostWr), .strobe(strobe), .page(page), .regRdData(regRdData),
    .devChanged(devChanged), .devPageMask(devPageMask)
  );

  pmw_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGES(PAGES), .CTRL_OFF(CTRL_OFF),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .PSEL_OFF(PSEL_OFF),
    .PWM_PAGE(PWM_PAGE), .PWM_OFF(PWM_OFF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .page(page), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRd(hostRd), .regRdData(regRdData),
    .hostRdData(hostRdData), .devRdPage(devRdPage), .devRdOff(devRdOff),
    .devRdData(devRdData), .pwmOut(pwmOut)
  );
endmodule

// File: tb/paged_mon_window_test.sv
module paged_mon_window_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  hostAddr = '0, hostWrData = '0;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0]  hostRdData;
  logic [3:0]  devRdPage = '0;
  logic [7:0]  devRdOff = '0;
  logic [7:0]  devRdData;
  logic        devChanged;
  logic [15:0] devPageMask;
  logic        pwmOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  paged_mon_window uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostWr(hostWr), .hostRd(hostRd), .hostRdData(hostRdData),
    .devRdPage(devRdPage), .devRdOff(devRdOff), .devRdData(devRdData),
    .devChanged(devChanged), .devPageMask(devPageMask), .pwmOut(pwmOut)
  );

  // {isWrite, req, addr, data, expected}
  localparam int NVEC = 22;
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 4'd1, 8'h04, 8'h00, 8'h01},  // R1 control after reset
    {1'b0, 4'd1, 8'hFF, 8'h00, 8'h00},  // R1 page select after reset
    {1'b0, 4'd1, 8'h98, 8'h00, 8'h00},  // R1 page bytes cleared
    {1'b1, 4'd4, 8'h04, 8'h00, 8'h00},  // open lock
    {1'b1, 4'd3, 8'hFF, 8'h01, 8'h00},  // page 1
    {1'b1, 4'd4, 8'h98, 8'h40, 8'h00},
    {1'b0, 4'd4, 8'h98, 8'h00, 8'h40},  // R4 stored
    {1'b1, 4'd3, 8'hFF, 8'hF3, 8'h00},  // page 3, upper bits set
    {1'b0, 4'd3, 8'hFF, 8'h00, 8'h03},  // R3 upper read zero
    {1'b0, 4'd3, 8'h98, 8'h00, 8'h00},  // R3 new page seen at once
    {1'b1, 4'd4, 8'h10, 8'hAA, 8'h00},
    {1'b0, 4'd4, 8'h10, 8'h00, 8'hAA},  // R4 low edge of window
    {1'b1, 4'd4, 8'hFE, 8'h55, 8'h00},
    {1'b0, 4'd4, 8'hFE, 8'h00, 8'h55},  // R4 high edge of window
    {1'b1, 4'd2, 8'h05, 8'h77, 8'h00},
    {1'b0, 4'd2, 8'h05, 8'h00, 8'h00},  // R2 undefined reads zero
    {1'b0, 4'd2, 8'h00, 8'h00, 8'h00},  // R2
    {1'b0, 4'd2, 8'h0F, 8'h00, 8'h00},  // R2
    {1'b0, 4'd2, 8'h04, 8'h00, 8'h00},  // R2 control untouched by 0x05 write
    {1'b1, 4'd3, 8'hFF, 8'h01, 8'h00},
    {1'b0, 4'd4, 8'h10, 8'h00, 8'h00},  // R4 page 1 separate from page 3
    {1'b0, 4'd4, 8'h98, 8'h00, 8'h40}   // R4
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostReadChk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    #1;
    chk(tag, 32'(hostRdData), 32'(exp), $sformatf("read 0x%02h", a));
    hostRd = 1'b0;
  endtask

  task automatic pwmChk(input int exp, input string tag);
    int hi = 0;
    repeat (256) begin
      @(negedge clk);
      if (pwmOut) hi++;
    end
    chk(tag, 32'(hi), 32'(exp), "pwm high cycles per 256");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset outputs
    chk("R1", 32'(devChanged), 0, "devChanged after reset");
    chk("R1", 32'(devPageMask), 0, "mask after reset");
    chk("R1", 32'(pwmOut), 0, "pwm after reset");

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][28]) hostWrite(VEC[i][23:16], VEC[i][15:8]);
      else hostReadChk(VEC[i][23:16], VEC[i][7:0], $sformatf("R%0d", VEC[i][27:24]));
    end

    // R8 duty zero before any commit
    pwmChk(0, "R8");

    // R6 commit pulse with mask of pages 1 and 3
    hostWrite(8'h04, 8'h01);
    chk("R6", 32'(devChanged), 1, "pulse after commit");
    chk("R6", 32'(devPageMask), 32'h000A, "mask pages 1,3");
    @(negedge clk);
    chk("R6", 32'(devChanged), 0, "pulse one cycle only");
    pwmChk(64, "R8");

    // R5 locked window write ignored, error set
    hostWrite(8'h98, 8'h99);
    chk("R5", 32'(devChanged), 0, "no pulse on locked write");
    hostReadChk(8'h98, 8'h40, "R5");
    hostReadChk(8'h04, 8'h03, "R5");

    // R6 setting lock when already set: no pulse, R5 bit1=0 keeps error
    hostWrite(8'h04, 8'h01);
    chk("R6", 32'(devChanged), 0, "no pulse when already locked");
    hostReadChk(8'h04, 8'h03, "R5");

    // R7 read gated by hostRd
    @(negedge clk);
    hostAddr = 8'h98; hostRd = 1'b0;
    #1 chk("R7", 32'(hostRdData), 0, "data with hostRd low");

    // unlock, edit duty byte without commit
    hostWrite(8'h04, 8'h00);
    hostReadChk(8'h04, 8'h02, "R5");
    hostWrite(8'h98, 8'hC0);
    pwmChk(64, "R8");  // R8 uncommitted value not used

    // combined: commit and clear error in one write
    hostWrite(8'h04, 8'h03);
    chk("R6", 32'(devChanged), 1, "pulse on combined write");
    chk("R6", 32'(devPageMask), 32'h0002, "mask page 1");
    hostReadChk(8'h04, 8'h01, "R5");
    pwmChk(192, "R8");

    // R9 device read port
    devRdPage = 4'd3; devRdOff = 8'h10;
    #1 chk("R9", 32'(devRdData), 32'hAA, "dev page3 0x10");
    devRdOff = 8'hFE;
    #1 chk("R9", 32'(devRdData), 32'h55, "dev page3 0xFE");
    devRdOff = 8'h05;
    #1 chk("R9", 32'(devRdData), 0, "dev outside window");
    devRdPage = 4'd1; devRdOff = 8'h98;
    #1 chk("R9", 32'(devRdData), 32'hC0, "dev page1 0x98");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule